// File: doc/BRIEF.md
# UART FIFO Core with Hardware Flow Control

This block holds the receive and transmit queues of a 16550-style serial port and runs the hardware handshake lines. On the receive side it accepts characters from a serial deframer. Each character carries three per-character error bits, and the block stores it in an 11-bit entry. The host reads that entry out. On the transmit side the host writes bytes, and a serializer pulls them out one character at a time.

Three queue modes are available. In the 450-compatible mode each queue is a single holding register. In the standard mode each queue holds `STD_DEPTH` entries. In the extended mode each queue holds `DEPTH` entries, and the receive trigger and auto-RTS levels scale up by `DEPTH/STD_DEPTH`. A subsystem port can take over the serial path. While bypass is on, that port loads the receive queue and unloads the transmit queue directly. The deframer and serializer strobes are then ignored, and the interrupt request behaves as it does in serial operation.

The block drives an active-high `rts` request. When `auto_cts_en` is set, it withholds new characters from the serializer while `cts` is low. It also reports both queue levels, a sticky overrun flag and a receive-data-available request.

Top module: `uart_fifo_core`

## Requirements
- R1: After reset both levels are 0, `ovr_flag` is 0, `rx_irq` is 0, `ser_valid` is 0 and `rts` is 1.
- R2: The capacity of each queue is 1 when `mode`=0, `STD_DEPTH` when `mode`=1, and `DEPTH` when `mode` is 2 or 3. A host write to a full transmit queue is dropped.
- R3: Both queues are first-in first-out. `host_rd_data[7:0]` is the character and `host_rd_data[10:8]` holds its error bits. Entries written through the subsystem port carry error bits 000.
- R4: When `auto_rts_en`=1 and `mode`≠0, `rts` is 0 while the receive level is at or above the threshold and 1 while it is below. The threshold is `STD_DEPTH-2` in mode 1 and `(STD_DEPTH-2)*DEPTH/STD_DEPTH` in extended mode. In every other case `rts` is 1.
- R5: `ser_valid` is 1 only when the transmit queue is non-empty, bypass is off, and `cts`=1 or `auto_cts_en`=0. A `ser_rd` while `ser_valid` is 0 has no effect. Because the serializer pulls only at character starts, CTS acts only at character boundaries.
- R6: A receive write into a full queue discards the character and sets `ovr_flag`. A pulse on `lsr_rd` clears the flag.
- R7: While `bypass_en`=1, `sub_wr` loads the receive queue and `sub_rd` pops the transmit queue. `dfr_wr` and `ser_rd` are ignored.
- R8: `rx_irq` follows the receive level. In mode 0 it is set for a level of 1 or more. In the FIFO modes it is set when the level is at least the selected trigger. For `rx_trig_sel` 0/1/2/3 the triggers are 1, `STD_DEPTH/4`, `STD_DEPTH/2` and `STD_DEPTH-2`. In extended mode the last three are multiplied by `DEPTH/STD_DEPTH`. The same rule applies in bypass.
- R9: A read and a write in the same cycle leave the level unchanged. Fullness is judged before that cycle's read, so a write to a full queue is still dropped.
- R10: A read of an empty queue leaves the level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0: 450, 1: standard FIFO, 2/3: extended FIFO |
| rx_trig_sel | input | 2 | Receive trigger select |
| auto_rts_en | input | 1 | Enable automatic RTS |
| auto_cts_en | input | 1 | Enable CTS gating of transmission |
| bypass_en | input | 1 | Subsystem bypass of the serial path |
| dfr_wr | input | 1 | Deframer character strobe |
| dfr_data | input | 8 | Deframer character |
| dfr_err | input | 3 | Deframer error bits |
| host_rd | input | 1 | Host pop of receive queue |
| host_rd_data | output | 11 | Receive queue head {err, char} |
| lsr_rd | input | 1 | Line status read, clears overrun |
| ovr_flag | output | 1 | Sticky overrun |
| host_wr | input | 1 | Host push to transmit queue |
| host_wr_data | input | 8 | Host transmit byte |
| ser_rd | input | 1 | Serializer pop at character start |
| ser_valid | output | 1 | Character available to serializer |
| ser_data | output | 8 | Transmit queue head |
| sub_wr | input | 1 | Subsystem push to receive queue |
| sub_wr_data | input | 8 | Subsystem receive byte |
| sub_rd | input | 1 | Subsystem pop of transmit queue |
| sub_rd_data | output | 8 | Transmit queue head for subsystem |
| cts | input | 1 | Clear to send, active high |
| rts | output | 1 | Request to send, active high |
| rx_level | output | $clog2(DEPTH+1) | Receive entries held |
| tx_level | output | $clog2(DEPTH+1) | Transmit entries held |
| rx_irq | output | 1 | Receive data available request |

## Verification
The bench builds the block with `DEPTH`=32 and `STD_DEPTH`=8. With these values the mode capacities are 1, 8 and 32, the standard triggers are 1/2/4/6 and the extended triggers are 1/8/16/24. This small size lets every queue level in every mode be visited, with every trigger selection compared at each level. It also brings each fill past capacity, so overrun, dropped writes and the RTS release on drain are all reached in a few hundred cycles.

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
  parameter int DEPTH     = 64,
  parameter int STD_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   mode,
  input  logic [1:0]                   rx_trig_sel,
  input  logic                         auto_rts_en,
  input  logic                         auto_cts_en,
  input  logic                         bypass_en,
  input  logic                         dfr_wr,
  input  logic [7:0]                   dfr_data,
  input  logic [2:0]                   dfr_err,
  input  logic                         host_rd,
  output logic [10:0]                  host_rd_data,
  input  logic                         lsr_rd,
  output logic                         ovr_flag,
  input  logic                         host_wr,
  input  logic [7:0]                   host_wr_data,
  input  logic                         ser_rd,
  output logic                         ser_valid,
  output logic [7:0]                   ser_data,
  input  logic                         sub_wr,
  input  logic [7:0]                   sub_wr_data,
  input  logic                         sub_rd,
  output logic [7:0]                   sub_rd_data,
  input  logic                         cts,
  output logic                         rts,
  output logic [$clog2(DEPTH+1)-1:0]   rx_level,
  output logic [$clog2(DEPTH+1)-1:0]   tx_level,
  output logic                         rx_irq
);
  localparam int LW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);
  localparam int K  = DEPTH / STD_DEPTH;

  logic [10:0]   rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [LW-1:0] rx_cnt, tx_cnt, cap, trig, rts_thr;
  logic          fifo_on, ext;

  assign fifo_on = mode != 2'd0;
  assign ext     = mode[1];

  always_comb begin
    case (mode)
      2'd0:    cap = LW'(1);
      2'd1:    cap = LW'(STD_DEPTH);
      default: cap = LW'(DEPTH);
    endcase
    case (rx_trig_sel)
      2'd0:    trig = LW'(1);
      2'd1:    trig = ext ? LW'(STD_DEPTH/4*K) : LW'(STD_DEPTH/4);
      2'd2:    trig = ext ? LW'(STD_DEPTH/2*K) : LW'(STD_DEPTH/2);
      default: trig = ext ? LW'((STD_DEPTH-2)*K) : LW'(STD_DEPTH-2);
    endcase
  end
  assign rts_thr = ext ? LW'((STD_DEPTH-2)*K) : LW'(STD_DEPTH-2);

  logic        rx_req, rx_full, rx_we, rx_re;
  logic [10:0] rx_wdata;
  assign rx_req   = bypass_en ? sub_wr : dfr_wr;
  assign rx_wdata = bypass_en ? {3'b000, sub_wr_data} : {dfr_err, dfr_data};
  assign rx_full  = rx_cnt >= cap;
  assign rx_we    = rx_req && !rx_full;
  assign rx_re    = host_rd && rx_cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; ovr_flag <= 1'b0;
    end else begin
      if (rx_we) rx_wp <= rx_wp + 1'b1;
      if (rx_re) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + LW'(rx_we) - LW'(rx_re);
      if (rx_req && rx_full) ovr_flag <= 1'b1;
      else if (lsr_rd)       ovr_flag <= 1'b0;
    end
  end
  always_ff @(posedge clk) if (rx_we) rx_mem[rx_wp] <= rx_wdata;

  logic tx_we, tx_re, tx_pop;
  assign ser_valid = !bypass_en && tx_cnt != '0 && (!auto_cts_en || cts);
  assign tx_we     = host_wr && tx_cnt < cap;
  assign tx_pop    = bypass_en ? sub_rd : (ser_rd && ser_valid);
  assign tx_re     = tx_pop && tx_cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_we) tx_wp <= tx_wp + 1'b1;
      if (tx_re) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + LW'(tx_we) - LW'(tx_re);
    end
  end
  always_ff @(posedge clk) if (tx_we) tx_mem[tx_wp] <= host_wr_data;

  assign host_rd_data = rx_mem[rx_rp];
  assign ser_data     = tx_mem[tx_rp];
  assign sub_rd_data  = tx_mem[tx_rp];
  assign rx_level     = rx_cnt;
  assign tx_level     = tx_cnt;
  assign rts          = !(auto_rts_en && fifo_on && rx_cnt >= rts_thr);
  assign rx_irq       = fifo_on ? (rx_cnt >= trig) : (rx_cnt != '0);

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_full && !host_rd) |=> (ovr_flag && rx_level == $past(rx_level)));
  p_tx_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && tx_cnt >= cap && !tx_pop) |=> tx_level == $past(tx_level));
  p_cts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && auto_cts_en && !cts && !host_wr) |=> tx_level == $past(tx_level));
  p_bypass_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && !sub_wr && !host_rd) |=> rx_level == $past(rx_level));
  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && !rx_req) |=> rx_level == '0);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH) && tx_level <= LW'(DEPTH));
endmodule

// File: tb/test_uart_fifo_core.sv
module test_uart_fifo_core;
  localparam int D = 32, S = 8, LW = $clog2(D+1);
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0, sel = 0;
  logic arts = 0, acts = 0, byp = 0, dfr_wr = 0, host_rd = 0, lsr_rd = 0;
  logic host_wr = 0, ser_rd = 0, sub_wr = 0, sub_rd = 0, cts = 0;
  logic [7:0] dfr_data = 0, hw_data = 0, sw_data = 0;
  logic [2:0] dfr_err = 0;
  logic [10:0] hr_data;
  logic [7:0] s_data, sr_data;
  logic ovr, s_valid, rts, irq;
  logic [LW-1:0] rxl, txl;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  uart_fifo_core #(.DEPTH(D), .STD_DEPTH(S)) i_uart_fifo_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_trig_sel(sel),
    .auto_rts_en(arts), .auto_cts_en(acts), .bypass_en(byp),
    .dfr_wr(dfr_wr), .dfr_data(dfr_data), .dfr_err(dfr_err),
    .host_rd(host_rd), .host_rd_data(hr_data), .lsr_rd(lsr_rd), .ovr_flag(ovr),
    .host_wr(host_wr), .host_wr_data(hw_data), .ser_rd(ser_rd), .ser_valid(s_valid),
    .ser_data(s_data), .sub_wr(sub_wr), .sub_wr_data(sw_data), .sub_rd(sub_rd),
    .sub_rd_data(sr_data), .cts(cts), .rts(rts), .rx_level(rxl), .tx_level(txl),
    .rx_irq(irq));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FIFO check FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int trig_of(int m, int s);
    int t;
    t = (s == 0) ? 1 : (s == 1) ? S/4 : (s == 2) ? S/2 : S-2;
    if (m >= 2 && s != 0) t = t * (D/S);
    return t;
  endfunction

  function automatic logic [7:0] pat(int m, int i);
    return 8'((m*40 + i*7 + 3) & 255);
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FIFO check FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk("R1 rx_level", int'(rxl), 0); chk("R1 tx_level", int'(txl), 0);
    chk("R1 ovr", int'(ovr), 0); chk("R1 irq", int'(irq), 0);
    chk("R1 ser_valid", int'(s_valid), 0); chk("R1 rts", int'(rts), 1);

    for (int m = 0; m < 3; m++) begin
      int cap, thr, lvl;
      mode = 2'(m); arts = 1;
      cap = (m == 0) ? 1 : (m == 1) ? S : D;
      thr = (m == 1) ? S-2 : (S-2)*(D/S);
      for (int i = 0; i < cap + 2; i++) begin
        dfr_wr = 1; dfr_data = pat(m, i); dfr_err = 3'(i % 8);
        tick(); dfr_wr = 0;
        lvl = (i + 1 < cap) ? i + 1 : cap;
        chk("R2 rx capacity", int'(rxl), lvl);
        chk("R6 overrun", int'(ovr), (i >= cap) ? 1 : 0);
        chk("R4 rts fill", int'(rts), (m == 0) ? 1 : (lvl < thr ? 1 : 0));
        for (int s = 0; s < 4; s++) begin
          sel = 2'(s); #1;
          chk("R8 irq trigger", int'(irq), (m == 0) ? 1 : (lvl >= trig_of(m, s) ? 1 : 0));
        end
      end
      lsr_rd = 1; tick(); lsr_rd = 0;
      chk("R6 overrun clear", int'(ovr), 0);
      for (int i = 0; i < cap; i++) begin
        chk("R3 rx data order", int'(hr_data), int'({3'(i % 8), pat(m, i)}));
        host_rd = 1; tick(); host_rd = 0;
        chk("R2 rx drain", int'(rxl), cap - 1 - i);
        chk("R4 rts drain", int'(rts), (m == 0) ? 1 : ((cap - 1 - i) < thr ? 1 : 0));
      end
      host_rd = 1; tick(); host_rd = 0;
      chk("R10 empty read", int'(rxl), 0);

      acts = 1; cts = 0;
      for (int i = 0; i < cap + 1; i++) begin
        host_wr = 1; hw_data = pat(m + 3, i); tick(); host_wr = 0;
        chk("R2 tx capacity", int'(txl), (i + 1 < cap) ? i + 1 : cap);
      end
      chk("R5 cts low valid", int'(s_valid), 0);
      ser_rd = 1; tick(); ser_rd = 0;
      chk("R5 cts low no pop", int'(txl), cap);
      cts = 1;
      for (int i = 0; i < cap; i++) begin
        #1 chk("R5 cts high valid", int'(s_valid), 1);
        chk("R3 tx data order", int'(s_data), int'(pat(m + 3, i)));
        ser_rd = 1; tick(); ser_rd = 0;
        chk("R5 tx drain", int'(txl), cap - 1 - i);
      end
      chk("R5 empty valid", int'(s_valid), 0);
      acts = 0; cts = 0;
    end

    mode = 2; sel = 0;
    for (int i = 0; i < 3; i++) begin
      dfr_wr = 1; dfr_data = 8'(i); dfr_err = 0; tick();
    end
    dfr_wr = 0;
    for (int i = 0; i < 5; i++) begin
      chk("R9 same-cycle order", int'(hr_data[7:0]), i);
      dfr_wr = 1; dfr_data = 8'(i + 3); host_rd = 1; tick();
      chk("R9 same-cycle level", int'(rxl), 3);
    end
    dfr_wr = 0; host_rd = 0;
    repeat (3) begin host_rd = 1; tick(); end
    host_rd = 0;
    mode = 0;
    dfr_wr = 1; dfr_data = 8'h11; tick();
    chk("R9 holding load", int'(rxl), 1);
    dfr_data = 8'h22; host_rd = 1; tick(); dfr_wr = 0; host_rd = 0;
    chk("R9 full write dropped", int'(rxl), 0);
    chk("R9 full write overrun", int'(ovr), 1);
    lsr_rd = 1; tick(); lsr_rd = 0;

    mode = 2; byp = 1; cts = 1;
    dfr_wr = 1; dfr_data = 8'h77; tick(); dfr_wr = 0;
    chk("R7 deframer ignored", int'(rxl), 0);
    sub_wr = 1; sw_data = 8'h5A; tick(); sub_wr = 0;
    chk("R7 sub write level", int'(rxl), 1);
    chk("R3 sub write zero err", int'(hr_data), 11'h05A);
    chk("R8 irq in bypass", int'(irq), 1);
    host_wr = 1; hw_data = 8'h33; tick(); host_wr = 0;
    chk("R5 bypass valid", int'(s_valid), 0);
    ser_rd = 1; tick(); ser_rd = 0;
    chk("R7 serializer ignored", int'(txl), 1);
    chk("R7 sub read data", int'(sr_data), 8'h33);
    sub_rd = 1; tick(); sub_rd = 0;
    chk("R7 sub read pop", int'(txl), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule